// File: doc/BRIEF.md
# Data-Strobe Receive Deserializer with System-Clock Resync

This block takes the two wires of a received data-strobe pair, the data bit from the A pair and the strobe bit from the B pair, and recovers the bit stream from them. Every transition of the exclusive-OR of the two lines marks one new bit. The value of that bit is the level of the data line. The recovered bits are grouped into parallel words of 2, 4 or 8 bits, according to the receive speed code. Each word is then handed across an asynchronous FIFO into the local system-clock domain. There it appears on a parallel bus with a one-cycle valid strobe, ready for a link-layer interface.

The speed code is sampled while the line is idle and then frozen for the whole packet. A packet ends when both lines have been low for a set number of system clocks. At that point any partly assembled word is thrown away. If words arrive faster than the system clock drains them and the FIFO fills, the surplus words are dropped and a sticky overflow flag is raised. Only reset clears that flag.

Top module: `ds_rx_deser`

## Requirements
- R1: While reset is asserted, and in the cycle after it, rx_valid and rx_overflow are low. After reset no word is delivered until bits arrive.
- R2: Each transition of rx_data XOR rx_strobe carries exactly one bit, whose value is the rx_data level. A sender keeps rx_data equal to the bit and toggles rx_strobe only when a bit repeats the previous rx_data value. Both lines rest low when idle.
- R3: With speed code 2'b00, every 2 bits form one word in rx_word[1:0], and rx_word[7:2] are zero.
- R4: With speed code 2'b01, every 4 bits form one word in rx_word[3:0], and rx_word[7:4] are zero.
- R5: With speed code 2'b10 or 2'b11, every 8 bits form one word in rx_word[7:0].
- R6: The first bit of each word is its most significant bit, within the word width.
- R7: The speed code is taken while the line is idle. A change of rx_speed during a packet has no effect on the width of that packet's words.
- R8: When both lines stay low for IDLE_CYCLES system clocks, the packet is over. The bits of an incomplete word are discarded, and the next packet starts a fresh word.
- R9: Every complete word is delivered exactly once, in arrival order, with rx_valid high for one system-clock cycle per word.
- R10: A word that completes while the FIFO is full is dropped, and rx_overflow goes high and stays high until reset. The words that are delivered keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Local system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Received data line (A pair) |
| rx_strobe | input | 1 | Received strobe line (B pair) |
| rx_speed | input | 2 | Receive speed code: 00 = 2-bit, 01 = 4-bit, 1x = 8-bit words |
| rx_word | output | 8 | Delivered word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe per delivered word |
| rx_overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
Two things can happen in the same system-clock cycle. A word can complete and be written into the FIFO at the very moment the read side is taking out an earlier word, and the overflow flag can be raised while delivery is still going on. The bench provokes this with bursts of 2-bit words at one bit per nanosecond, which is far above the drain rate. It judges the result in two ways. The flag must be set and must stay set. Every delivered word must appear, in order, within the sequence that was sent. A following packet must then arrive intact.

// File: rtl/ds_rx_pkg.sv
// Shared constants and speed decoding for the data-strobe receiver.
// Assumes the widest word is 8 bits and words are built from bit pairs.
package ds_rx_pkg;

    localparam int WORD_W   = 8;
    localparam int PAIR_W   = $clog2(WORD_W / 2);

    typedef enum logic [1:0] {
        SPD_W2  = 2'b00,
        SPD_W4  = 2'b01,
        SPD_W8  = 2'b10,
        SPD_W8X = 2'b11
    } rx_speed_e;

    // Index of the last bit pair in a word for a given speed code.
    function automatic logic [PAIR_W-1:0] last_pair(input logic [1:0] spd);
        case (spd)
            SPD_W2:  return PAIR_W'(0);
            SPD_W4:  return PAIR_W'(1);
            default: return PAIR_W'(WORD_W / 2 - 1);
        endcase
    endfunction

    // Mask that keeps only the bits belonging to a word of the given speed.
    function automatic logic [WORD_W-1:0] word_mask(input logic [1:0] spd);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < 2 * (int'(last_pair(spd)) + 1)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ds_line_monitor.sv
// Watches the line from the system-clock side: synchronizes both wires,
// detects the end of a packet by an idle timeout, freezes the speed code
// for the packet, and makes the reset and clear pulses for the bit domain.
// Assumes rx_speed is steady for a few system clocks before a packet begins.
module ds_line_monitor #(
    parameter int IDLE_CYCLES = 16,
    parameter int SYNC_N      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_d,
    input  logic       line_s,
    input  logic [1:0] speed_in,
    output logic [1:0] speed_hold,
    output logic       idle,
    output logic       bit_rst,
    output logic       bit_clr
);
    localparam int CW = $clog2(IDLE_CYCLES);

    logic [SYNC_N-1:0] d_sync, s_sync;
    logic [CW-1:0]     idle_cnt;
    logic              active;
    logic              timeout;

    // Bring both line wires into the system-clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_sync <= '0;
            s_sync <= '0;
        end else begin
            d_sync <= {d_sync[SYNC_N-2:0], line_d};
            s_sync <= {s_sync[SYNC_N-2:0], line_s};
        end
    end

    assign active  = d_sync[SYNC_N-1] | s_sync[SYNC_N-1];
    assign timeout = !idle && !active && (idle_cnt == CW'(IDLE_CYCLES - 1));

    // Idle timeout and per-packet capture of the speed code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt   <= '0;
            idle       <= 1'b1;
            speed_hold <= 2'b00;
        end else if (active) begin
            idle_cnt <= '0;
            idle     <= 1'b0;
        end else if (!idle) begin
            if (timeout) begin
                idle_cnt <= '0;
                idle     <= 1'b1;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end else begin
            speed_hold <= speed_in;
        end
    end

    // Registered reset and clear pulses for the recovered-clock domain.
    always_ff @(posedge clk) begin
        bit_rst <= !rst_n;
        bit_clr <= rst_n && timeout;
    end

endmodule

// File: rtl/ds_bit_deser.sv
// Recovered-clock deserializer. The even bit of each pair is taken on the
// rising edge of the recovered clock, and the odd bit on the falling edge
// (rising edge of bclk_n). Pairs are shifted in first-bit-first, so the
// first bit ends up as the word MSB.
// Assumes the line starts each packet with the recovered clock low.
module ds_bit_deser
    import ds_rx_pkg::*;
(
    input  logic              bclk,
    input  logic              bclk_n,
    input  logic              line_d,
    input  logic              arst,
    input  logic              aclr,
    input  logic [1:0]        spd,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    logic              even_bit;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] sh_next;
    logic [PAIR_W-1:0] pair_cnt;
    logic              clr_any;

    assign clr_any = arst | aclr;

    // Capture the first bit of each pair on the rising recovered edge.
    always_ff @(posedge bclk or posedge arst) begin
        if (arst) even_bit <= 1'b0;
        else      even_bit <= line_d;
    end

    assign sh_next   = {shreg[WORD_W-3:0], even_bit, line_d};
    assign word_done = (pair_cnt == last_pair(spd));
    assign word      = sh_next & word_mask(spd);

    // Shift in completed pairs and count them towards a word.
    always_ff @(posedge bclk_n or posedge clr_any) begin
        if (clr_any) begin
            shreg    <= '0;
            pair_cnt <= '0;
        end else begin
            shreg    <= sh_next;
            pair_cnt <= word_done ? '0 : pair_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ds_async_fifo.sv
// Asynchronous FIFO with Gray-coded pointers. The write side runs on the
// recovered clock, and the read side on the system clock. Reads happen as
// soon as data is present, with no back-pressure. Writes into a full FIFO
// are dropped and latch a sticky flag, which is synchronized to the read side.
// Assumes AW >= 2.
module ds_async_fifo #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rclk,
    input  logic         rrst_n,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         ovf
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rq1, rq2;
    logic [AW:0]  rbin, rgray, wq1, wq2;
    logic         wovf, oq1, oq2;
    logic         full, empty;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    assign full  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign empty = (rgray == wq2);

    // Write pointer and sticky overflow in the recovered domain.
    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            wovf  <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                wovf <= 1'b1;
            end else begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
        end
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Read pointer synchronized into the recovered domain.
    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) begin
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
        end
    end

    // Read side: synchronize the write pointer and flag, pop one word per cycle.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            wq1      <= '0;
            wq2      <= '0;
            oq1      <= 1'b0;
            oq2      <= 1'b0;
            ovf      <= 1'b0;
            rbin     <= '0;
            rgray    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            oq1 <= wovf;
            oq2 <= oq1;
            ovf <= ovf | oq2;
            if (!empty) begin
                rd_data  <= mem[rbin[AW-1:0]];
                rd_valid <= 1'b1;
                rbin     <= rbin + 1'b1;
                rgray    <= to_gray(rbin + 1'b1);
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ds_rx_deser.sv
// Top of the data-strobe receiver. It recovers the bit clock as
// data XOR strobe, deserializes at the held speed, and resynchronizes
// words to sys_clk through an asynchronous FIFO.
// Assumes the line is idle (both low) when reset is released.
module ds_rx_deser
    import ds_rx_pkg::*;
#(
    parameter int IDLE_CYCLES = 16,
    parameter int FIFO_AW     = 3,
    parameter int SYNC_N      = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              rx_data,
    input  logic              rx_strobe,
    input  logic [1:0]        rx_speed,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_overflow
);
    logic              bclk, bclk_n;
    logic [1:0]        spd_hold;
    logic              pkt_idle;
    logic              bit_rst, bit_clr;
    logic              word_done;
    logic [WORD_W-1:0] word;

    assign bclk   = rx_data ^ rx_strobe;
    assign bclk_n = ~bclk;

    ds_line_monitor #(.IDLE_CYCLES(IDLE_CYCLES), .SYNC_N(SYNC_N)) u_mon (
        .clk        (sys_clk),
        .rst_n      (sys_rst_n),
        .line_d     (rx_data),
        .line_s     (rx_strobe),
        .speed_in   (rx_speed),
        .speed_hold (spd_hold),
        .idle       (pkt_idle),
        .bit_rst    (bit_rst),
        .bit_clr    (bit_clr)
    );

    ds_bit_deser u_deser (
        .bclk      (bclk),
        .bclk_n    (bclk_n),
        .line_d    (rx_data),
        .arst      (bit_rst),
        .aclr      (bit_clr),
        .spd       (spd_hold),
        .word_done (word_done),
        .word      (word)
    );

    ds_async_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
        .wclk     (bclk_n),
        .wrst     (bit_rst),
        .wr_en    (word_done),
        .wr_data  (word),
        .rclk     (sys_clk),
        .rrst_n   (sys_rst_n),
        .rd_data  (rx_word),
        .rd_valid (rx_valid),
        .ovf      (rx_overflow)
    );

endmodule

// File: rtl/ds_rx_deser_chk.sv
// Property checker for ds_rx_deser, attached with bind.
module ds_rx_deser_chk (
    input logic       sys_clk,
    input logic       sys_rst_n,
    input logic       rx_valid,
    input logic       rx_overflow,
    input logic [7:0] rx_word,
    input logic [1:0] spd_hold,
    input logic       pkt_idle
);
    // R1
    reset_quiet_chk: assert property (@(posedge sys_clk)
        !sys_rst_n |=> (!rx_valid && !rx_overflow));

    // R10
    ovf_sticky_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rx_overflow |=> rx_overflow);

    // R3
    narrow_word_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (rx_valid && spd_hold == 2'b00) |-> (rx_word[7:2] == 6'd0));

    // R4
    mid_word_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (rx_valid && spd_hold == 2'b01) |-> (rx_word[7:4] == 4'd0));

    // R7
    speed_frozen_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !pkt_idle |=> $stable(spd_hold));

    // R10
    ovf_in_packet_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(rx_overflow) |-> !pkt_idle);
endmodule

bind ds_rx_deser ds_rx_deser_chk u_chk (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .rx_valid    (rx_valid),
    .rx_overflow (rx_overflow),
    .rx_word     (rx_word),
    .spd_hold    (spd_hold),
    .pkt_idle    (pkt_idle)
);

// File: tb/ds_rx_deser_bench.sv
module ds_rx_deser_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int IDLE = 16;

    logic       sys_clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic [1:0] ds = 2'b00;
    logic [1:0] spd = 2'b00;
    logic [7:0] rx_word;
    logic       rx_valid, rx_overflow;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    int bits_q[$];

    always #4 sys_clk = ~sys_clk;

    ds_rx_deser u_ds_rx_deser (
        .sys_clk     (sys_clk),
        .sys_rst_n   (sys_rst_n),
        .rx_data     (ds[1]),
        .rx_strobe   (ds[0]),
        .rx_speed    (spd),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid),
        .rx_overflow (rx_overflow)
    );

    // Collect every delivered word away from the active edge.
    always @(negedge sys_clk) if (sys_rst_n && rx_valid) got_q.push_back(rx_word);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    function automatic logic [7:0] word_at(input int start, input int w);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < w; i++) r = {r[6:0], bits_q[start + i][0]};
        return r;
    endfunction

    function automatic int period_for(input int w);
        return (w == 2) ? $urandom_range(6, 10) : (w == 4) ? $urandom_range(3, 8) : $urandom_range(2, 6);
    endfunction

    // Data-strobe encoding of one bit.
    task automatic drive_bit(input int b, input int per);
        if (b[0] != ds[1]) ds = {b[0], ds[0]};
        else               ds = {ds[1], ~ds[0]};
        #per;
    endtask

    // Send one packet; expected words are queued from the sent bits.
    task automatic send(input logic [1:0] s, input int nbits, input int per,
                        input bit keep_bits, input bit chg, input logic [1:0] s2);
        int w;
        spd = s;
        repeat (3) @(negedge sys_clk);
        #1;
        if (!keep_bits) begin
            bits_q.delete();
            for (int i = 0; i < nbits; i++) bits_q.push_back($urandom_range(0, 1));
        end
        w = width_of(s);
        for (int k = 0; k < nbits / w; k++) exp_q.push_back(word_at(k * w, w));
        for (int i = 0; i < nbits; i++) begin
            if (chg && i == nbits / 2) spd = s2;
            drive_bit(bits_q[i], per);
        end
        ds = 2'b00;
        repeat (IDLE + 12) @(negedge sys_clk);
        spd = s;
    endtask

    task automatic compare(input string req);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
        bits_q.delete();
    endtask

    task automatic set_bits(input logic [31:0] v, input int n);
        bits_q.delete();
        for (int i = n - 1; i >= 0; i--) bits_q.push_back(int'(v[i]));
    endtask

    task automatic do_reset();
        sys_rst_n = 1'b0;
        repeat (4) @(negedge sys_clk);
        chk(!rx_valid, "R1 valid in reset", rx_valid, 0);
        chk(!rx_overflow, "R1 overflow in reset", rx_overflow, 0);
        sys_rst_n = 1'b1;
        repeat (4) @(negedge sys_clk);
    endtask

    initial begin
        void'($urandom(32'd7741));
        do_reset();
        chk(got_q.size() == 0, "R1 no word after reset", got_q.size(), 0);

        // R3: 2-bit words from 1,0,1,1,0,0,0,1 -> 2,3,0,1
        set_bits(32'hB1, 8);
        send(2'b00, 8, 7, 1'b1, 1'b0, 2'b00);
        chk(exp_q.size() == 4 && exp_q[0] == 8'h2 && exp_q[1] == 8'h3, "R3 model", exp_q.size(), 4);
        compare("R3");

        // R4: 4-bit words
        send(2'b01, 16, 5, 1'b0, 1'b0, 2'b00);
        compare("R4");

        // R5: both 8-bit codes
        send(2'b10, 32, 2, 1'b0, 1'b0, 2'b00);
        send(2'b11, 16, 3, 1'b0, 1'b0, 2'b00);
        compare("R5");

        // R6: first bit is MSB
        set_bits(32'h80, 8);
        send(2'b10, 8, 4, 1'b1, 1'b0, 2'b00);
        chk(got_q.size() == 1 && got_q[0] == 8'h80, "R6 msb first", got_q.size() ? got_q[0] : -1, 8'h80);
        compare("R6");

        // R2: runs of equal bits move only the strobe
        set_bits(32'h0000FFFF, 32);
        send(2'b10, 32, 3, 1'b1, 1'b0, 2'b00);
        compare("R2");

        // R7: speed change inside a packet is ignored
        send(2'b00, 24, 7, 1'b0, 1'b1, 2'b10);
        compare("R7");

        // R8: a partial word is dropped at packet end
        set_bits(32'h3F, 6);
        send(2'b10, 6, 4, 1'b1, 1'b0, 2'b00);
        chk(got_q.size() == 0, "R8 partial word", got_q.size(), 0);
        set_bits(32'hA5, 8);
        send(2'b10, 8, 4, 1'b1, 1'b0, 2'b00);
        compare("R8");

        // R9: random packets, random speeds and bit periods
        for (int p = 0; p < 12; p++) begin
            logic [1:0] s;
            int w, nb;
            s  = 2'($urandom_range(0, 3));
            w  = width_of(s);
            nb = w * $urandom_range(1, 8);
            send(s, nb, period_for(w), 1'b0, 1'b0, 2'b00);
            compare("R9");
        end
        chk(!rx_valid, "R9 valid low when idle", rx_valid, 0);
        chk(!rx_overflow, "R10 no overflow yet", rx_overflow, 0);

        // R10: burst far above drain rate
        send(2'b00, 48, 1, 1'b0, 1'b0, 2'b00);
        chk(rx_overflow, "R10 overflow set", rx_overflow, 1);
        chk(got_q.size() < exp_q.size() && got_q.size() > 0, "R10 words dropped", got_q.size(), exp_q.size());
        begin
            int j = 0;
            bit ok = 1'b1;
            foreach (got_q[i]) begin
                while (j < exp_q.size() && exp_q[j] != got_q[i]) j++;
                if (j >= exp_q.size()) ok = 1'b0;
                j++;
            end
            chk(ok, "R10 order kept", 0, 1);
        end
        got_q.delete();
        exp_q.delete();
        send(2'b10, 32, 3, 1'b0, 1'b0, 2'b00);
        compare("R10 next packet");
        chk(rx_overflow, "R10 sticky", rx_overflow, 1);
        do_reset();
        chk(!rx_overflow, "R10 cleared by reset", rx_overflow, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule